// File: doc/BRIEF.md
# Multi-Lane PHY Power-Up Sequencer

This block is a hardware state machine that brings a serial PHY of up to `NLANES` lanes out of reset and through its PLL calibration. Software, or a neighbouring controller, issues single-cycle commands. An acquire command turns on the reference clock and holds the PHY in reset. An enable command runs the power-up sequence for one lane. A disable command is accepted and has no effect. The block drives the PHY reset, the reference clock enable, one transmit electrical-idle force bit per lane, and a small configuration test port made of a 6-bit address, a 4-bit data field and a write strobe. It watches two status inputs: PLL locked and PLL output pending.

An enable walks through three phases. In the first, the PLL must report lock. Two configuration writes then follow, one selecting the rate mode and one selecting the 100 MHz PLL setting. In the second phase, the PLL-output flag must drop to 0. In the third, the address is parked again and the PLL must report lock once more. Each phase polls its status at most `POLL_TRIES` times, with `POLL_WAIT` clock cycles between samples. A phase that runs out of attempts aborts the run with its own error code. A successful run marks the lane in a lanes-on bitmap, and that bit is never cleared.

The states are:
- `S_IDLE`: waits for a command.
- `S_RST_REL`: releases the PHY reset.
- `S_ADDR_SET`: parks address 0x10 on the test port.
- `S_IDLE_OFF`: clears the lane's idle force and starts the lock poll.
- `S_LOCK`: the lock poll.
- `S_WR1_GO` and `S_WR1_WAIT`: the first configuration write.
- `S_WR2_GO` and `S_WR2_WAIT`: the second configuration write, which then starts the output poll.
- `S_OUTPUT`: the output poll.
- `S_RELOCK_ADDR`: parks the address again and starts the relock poll.
- `S_RELOCK`: the relock poll.

The transitions are:
- `S_IDLE` to `S_RST_REL` on an accepted enable.
- Each non-poll state to the next one in the order above, after one cycle.
- `S_WR1_WAIT` and `S_WR2_WAIT` forward when the writer reports completion.
- `S_LOCK` to `S_WR1_GO`, `S_OUTPUT` to `S_RELOCK_ADDR`, and `S_RELOCK` to `S_IDLE` when the polled condition is met.
- `S_LOCK`, `S_OUTPUT` or `S_RELOCK` to `S_IDLE` on a timeout, with error code 1, 2 or 3 respectively.

Top module: `phy_pwrup_seq`

## Requirements
- R1: After reset:
  - `phy_rst`, `refclk_en`, `cfg_wr`, `busy`, `done`, `err` and `cmd_reject` are 0.
  - `cfg_addr`, `cfg_data`, `err_code` and `lanes_on` are 0.
  - Every `tx_idle_force` bit is 1.
- R2: A command whose `cmd_lane` is `NLANES` or more raises `cmd_reject` for exactly the next cycle. It leaves `busy` at 0 and leaves `lanes_on` and `tx_idle_force` unchanged.
- R3: An acquire command (`cmd_op` = 0) accepted while idle sets `refclk_en` and `phy_rst` to 1 from the next cycle. `busy` stays 0.
- R4: An enable command (`cmd_op` = 1) accepted while idle behaves as follows:
  - `busy` is 1 from the next cycle.
  - `phy_rst` is 0 from the second busy cycle.
  - The run ends with `busy` at 0 in the same cycle that exactly one of `done` or `err` is 1, and that pulse lasts one cycle.
- R5: Before the first status sample, `cfg_addr` holds 0x10 with `cfg_wr` at 0. The `tx_idle_force` bit of the requested lane then goes to 0, and only that bit changes. The bit stays 0 even if the run later fails.
- R6: The lock phase samples `pll_locked` for the value 1, at most `POLL_TRIES` times, `POLL_WAIT` cycles apart. On a timeout, `err_code` is 1 after exactly 3 + `POLL_TRIES` + (`POLL_TRIES` − 1)·`POLL_WAIT` busy cycles. A lock that arrives before the last sample lets the run continue.
- R7: After lock, the block makes exactly two strobed writes, in this order: address 0x10 with data 0x8, then address 0x12 with data 0x8. `cfg_addr` and `cfg_data` are stable in the cycle `cfg_wr` rises, while it is high, and in the cycle it falls.
- R8: The output phase samples `pll_out` for the value 0 under the same limits. On a timeout, `err_code` is 2.
- R9: The relock phase parks `cfg_addr` at 0x10 with no strobe, then samples `pll_locked` for the value 1 under the same limits. On a timeout, `err_code` is 3. A successful run ends with `cfg_addr` = 0x10 and `cfg_wr` = 0.
- R10: A successful run pulses `done` and leaves `err_code` at 0. It sets `lanes_on` bit `cmd_lane`. `lanes_on` bits only change in a `done` cycle and are never cleared.
- R11: Commands with `cmd_op` = 2 (disable) or 3 (unused) have no effect. `busy` stays 0 and `lanes_on` is unchanged.
- R12: Commands presented while `busy` is 1 are ignored. A lane enabled only while busy gets neither its `lanes_on` bit nor a cleared `tx_idle_force` bit.
- R13: `err_code` holds its last value while idle. The next accepted enable resets it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 0 acquire, 1 enable, 2 disable, 3 unused |
| cmd_lane | input | LANE_W | Lane index; values of `NLANES` or more are rejected |
| pll_locked | input | 1 | PLL lock status, synchronous to `clk` |
| pll_out | input | 1 | PLL output-pending status, synchronous to `clk` |
| phy_rst | output | 1 | PHY reset, active high |
| refclk_en | output | 1 | Reference clock enable |
| tx_idle_force | output | NLANES | Per-lane transmit electrical-idle force, 1 = forced |
| cfg_addr | output | 6 | Test port address |
| cfg_data | output | 4 | Test port write data |
| cfg_wr | output | 1 | Test port write strobe |
| busy | output | 1 | Power-up run in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | One-cycle pulse on timeout abort |
| err_code | output | 2 | 0 ok, 1 lock, 2 output, 3 relock timeout |
| lanes_on | output | NLANES | Lanes that completed power-up |
| cmd_reject | output | 1 | One-cycle pulse for an out-of-range lane |

## Verification
The properties take for granted four things about the inputs:
- `pll_locked` and `pll_out` are already synchronous to `clk`.
- `cmd_valid` is a pulse that carries a defined `cmd_op` and `cmd_lane`.
- `CFG_HOLD` and `POLL_WAIT` are at least 1.
- Nothing but the block itself moves the test port.

The bench keeps within these limits as follows:
- Its status model changes `pll_locked` and `pll_out` only at clock edges, as a function of how far the run has progressed.
- Commands are driven between edges, for exactly one cycle.
- Random lock and clear delays are drawn well inside the poll window, so random runs are expected to succeed.
- Timeouts come only from directed cases that never deliver the awaited status.

// File: rtl/phy_pwrup_pkg.sv
package phy_pwrup_pkg;

    localparam int CFG_ADDR_W = 6;
    localparam int CFG_DATA_W = 4;

    // test-port register addresses and field values used by the sequence
    localparam logic [CFG_ADDR_W-1:0] CA_CLK_TEST = 6'h10;
    localparam logic [CFG_ADDR_W-1:0] CA_CLK_SCC  = 6'h12;
    localparam logic [CFG_DATA_W-1:0] CD_RATE_SEL = 4'h8;
    localparam logic [CFG_DATA_W-1:0] CD_PLL_100M = 4'h8;

    typedef enum logic [1:0] {
        OP_ACQUIRE = 2'd0,
        OP_ENABLE  = 2'd1,
        OP_DISABLE = 2'd2,
        OP_SPARE   = 2'd3
    } cmd_op_e;

    typedef enum logic [1:0] {
        EC_OK     = 2'd0,
        EC_LOCK   = 2'd1,
        EC_OUTPUT = 2'd2,
        EC_RELOCK = 2'd3
    } err_code_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RST_REL,
        S_ADDR_SET,
        S_IDLE_OFF,
        S_LOCK,
        S_WR1_GO,
        S_WR1_WAIT,
        S_WR2_GO,
        S_WR2_WAIT,
        S_OUTPUT,
        S_RELOCK_ADDR,
        S_RELOCK
    } seq_state_e;

    typedef enum logic [1:0] {
        P_OFF,
        P_CHECK,
        P_WAIT
    } poll_phase_e;

    typedef enum logic [1:0] {
        W_IDLE,
        W_SETUP,
        W_STROBE,
        W_RELEASE
    } wr_phase_e;

endpackage

// File: rtl/phy_pwrup_poll.sv
module phy_pwrup_poll
    import phy_pwrup_pkg::*;
#(
    parameter int POLL_TRIES = 50,
    parameter int POLL_WAIT  = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cond,
    output logic ok,
    output logic tmo
);

    localparam int TRY_W  = $clog2(POLL_TRIES + 1);
    localparam int WAIT_W = $clog2(POLL_WAIT + 1);

    poll_phase_e        phase;
    logic [TRY_W-1:0]   tries;
    logic [WAIT_W-1:0]  wait_cnt;
    logic               last_try;
    logic               wait_end;

    assign last_try = (tries == TRY_W'(POLL_TRIES - 1));
    assign wait_end = (wait_cnt == WAIT_W'(POLL_WAIT - 1));

    assign ok  = (phase == P_CHECK) && cond;
    assign tmo = (phase == P_CHECK) && !cond && last_try;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= P_OFF;
            tries    <= '0;
            wait_cnt <= '0;
        end else if (start) begin
            phase    <= P_CHECK;
            tries    <= '0;
            wait_cnt <= '0;
        end else begin
            unique case (phase)
                P_OFF: begin
                    phase <= P_OFF;
                end
                P_CHECK: begin
                    if (cond || last_try) begin
                        phase <= P_OFF;
                    end else begin
                        phase    <= P_WAIT;
                        wait_cnt <= '0;
                        tries    <= tries + 1'b1;
                    end
                end
                P_WAIT: begin
                    if (wait_end) begin
                        phase <= P_CHECK;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                default: phase <= P_OFF;
            endcase
        end
    end

endmodule

// File: rtl/phy_pwrup_cfg_wr.sv
module phy_pwrup_cfg_wr
    import phy_pwrup_pkg::*;
#(
    parameter int CFG_HOLD = 100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  addr_load,
    input  logic                  start,
    input  logic [CFG_ADDR_W-1:0] addr_in,
    input  logic [CFG_DATA_W-1:0] data_in,
    output logic [CFG_ADDR_W-1:0] cfg_addr,
    output logic [CFG_DATA_W-1:0] cfg_data,
    output logic                  cfg_wr,
    output logic                  wr_done
);

    localparam int HOLD_W = $clog2(CFG_HOLD + 1);

    wr_phase_e          phase;
    logic [HOLD_W-1:0]  cnt;
    logic               step_end;

    assign step_end = (cnt == HOLD_W'(CFG_HOLD - 1));
    assign wr_done  = (phase == W_RELEASE) && step_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= W_IDLE;
            cnt      <= '0;
            cfg_addr <= '0;
            cfg_data <= '0;
            cfg_wr   <= 1'b0;
        end else begin
            unique case (phase)
                W_IDLE: begin
                    if (start) begin
                        cfg_addr <= addr_in;
                        cfg_data <= data_in;
                        cfg_wr   <= 1'b0;
                        cnt      <= '0;
                        phase    <= W_SETUP;
                    end else if (addr_load) begin
                        cfg_addr <= addr_in;
                        cfg_wr   <= 1'b0;
                    end
                end
                W_SETUP: begin
                    if (step_end) begin
                        cfg_wr <= 1'b1;
                        cnt    <= '0;
                        phase  <= W_STROBE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                W_STROBE: begin
                    if (step_end) begin
                        cfg_wr <= 1'b0;
                        cnt    <= '0;
                        phase  <= W_RELEASE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                W_RELEASE: begin
                    if (step_end) begin
                        phase <= W_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= W_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/phy_pwrup_lanes.sv
module phy_pwrup_lanes #(
    parameter int NLANES = 4,
    parameter int IDX_W  = $clog2(NLANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lane,
    input  logic              clear_idle,
    input  logic              set_on,
    output logic [NLANES-1:0] tx_idle_force,
    output logic [NLANES-1:0] lanes_on
);

    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        logic hit;
        assign hit = (lane == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tx_idle_force[i] <= 1'b1;
                lanes_on[i]      <= 1'b0;
            end else begin
                if (clear_idle && hit) begin
                    tx_idle_force[i] <= 1'b0;
                end
                if (set_on && hit) begin
                    lanes_on[i] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/phy_pwrup_seq.sv
module phy_pwrup_seq
    import phy_pwrup_pkg::*;
#(
    parameter int NLANES     = 4,
    parameter int POLL_TRIES = 50,
    parameter int POLL_WAIT  = 2_000_000,
    parameter int CFG_HOLD   = 100,
    parameter int LANE_W     = $clog2(NLANES) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [1:0]            cmd_op,
    input  logic [LANE_W-1:0]     cmd_lane,
    input  logic                  pll_locked,
    input  logic                  pll_out,
    output logic                  phy_rst,
    output logic                  refclk_en,
    output logic [NLANES-1:0]     tx_idle_force,
    output logic [CFG_ADDR_W-1:0] cfg_addr,
    output logic [CFG_DATA_W-1:0] cfg_data,
    output logic                  cfg_wr,
    output logic                  busy,
    output logic                  done,
    output logic                  err,
    output logic [1:0]            err_code,
    output logic [NLANES-1:0]     lanes_on,
    output logic                  cmd_reject
);

    localparam int IDX_W = LANE_W - 1;

    seq_state_e             state;
    seq_state_e             state_d;
    logic [IDX_W-1:0]       lane_q;

    logic                   accept;
    logic                   lane_ok;
    logic                   poll_start;
    logic                   poll_cond;
    logic                   poll_ok;
    logic                   poll_tmo;
    logic                   wr_start;
    logic                   wr_done;
    logic                   addr_load;
    logic [CFG_ADDR_W-1:0]  wr_addr;
    logic [CFG_DATA_W-1:0]  wr_data;
    logic                   clear_idle;
    logic                   set_on;
    logic                   fin;
    err_code_e              fin_code;

    assign accept  = cmd_valid && (state == S_IDLE);
    assign lane_ok = (cmd_lane < LANE_W'(NLANES));
    assign busy    = (state != S_IDLE);

    // output phase waits for the flag to clear; the other two wait for lock
    assign poll_cond = (state == S_OUTPUT) ? !pll_out : pll_locked;

    // next state and per-cycle control strobes
    always_comb begin
        state_d    = state;
        poll_start = 1'b0;
        wr_start   = 1'b0;
        wr_addr    = CA_CLK_TEST;
        wr_data    = CD_RATE_SEL;
        addr_load  = 1'b0;
        clear_idle = 1'b0;
        set_on     = 1'b0;
        fin        = 1'b0;
        fin_code   = EC_OK;
        unique case (state)
            S_IDLE: begin
                if (accept && lane_ok && (cmd_op == OP_ENABLE)) begin
                    state_d = S_RST_REL;
                end
            end
            S_RST_REL: begin
                state_d = S_ADDR_SET;
            end
            S_ADDR_SET: begin
                addr_load = 1'b1;
                state_d   = S_IDLE_OFF;
            end
            S_IDLE_OFF: begin
                clear_idle = 1'b1;
                poll_start = 1'b1;
                state_d    = S_LOCK;
            end
            S_LOCK: begin
                if (poll_ok) begin
                    state_d = S_WR1_GO;
                end else if (poll_tmo) begin
                    fin      = 1'b1;
                    fin_code = EC_LOCK;
                    state_d  = S_IDLE;
                end
            end
            S_WR1_GO: begin
                wr_start = 1'b1;
                state_d  = S_WR1_WAIT;
            end
            S_WR1_WAIT: begin
                if (wr_done) begin
                    state_d = S_WR2_GO;
                end
            end
            S_WR2_GO: begin
                wr_start = 1'b1;
                wr_addr  = CA_CLK_SCC;
                wr_data  = CD_PLL_100M;
                state_d  = S_WR2_WAIT;
            end
            S_WR2_WAIT: begin
                if (wr_done) begin
                    poll_start = 1'b1;
                    state_d    = S_OUTPUT;
                end
            end
            S_OUTPUT: begin
                if (poll_ok) begin
                    state_d = S_RELOCK_ADDR;
                end else if (poll_tmo) begin
                    fin      = 1'b1;
                    fin_code = EC_OUTPUT;
                    state_d  = S_IDLE;
                end
            end
            S_RELOCK_ADDR: begin
                addr_load  = 1'b1;
                poll_start = 1'b1;
                state_d    = S_RELOCK;
            end
            S_RELOCK: begin
                if (poll_ok) begin
                    set_on  = 1'b1;
                    fin     = 1'b1;
                    state_d = S_IDLE;
                end else if (poll_tmo) begin
                    fin      = 1'b1;
                    fin_code = EC_RELOCK;
                    state_d  = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phy_rst    <= 1'b0;
            refclk_en  <= 1'b0;
            done       <= 1'b0;
            err        <= 1'b0;
            err_code   <= EC_OK;
            cmd_reject <= 1'b0;
            lane_q     <= '0;
        end else begin
            done       <= fin && (fin_code == EC_OK);
            err        <= fin && (fin_code != EC_OK);
            cmd_reject <= accept && !lane_ok;
            if (accept && lane_ok) begin
                if (cmd_op == OP_ACQUIRE) begin
                    refclk_en <= 1'b1;
                    phy_rst   <= 1'b1;
                end else if (cmd_op == OP_ENABLE) begin
                    lane_q   <= cmd_lane[IDX_W-1:0];
                    err_code <= EC_OK;
                end
            end
            if (state == S_RST_REL) begin
                phy_rst <= 1'b0;
            end
            if (fin) begin
                err_code <= fin_code;
            end
        end
    end

    phy_pwrup_poll #(
        .POLL_TRIES (POLL_TRIES),
        .POLL_WAIT  (POLL_WAIT)
    ) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .start (poll_start),
        .cond  (poll_cond),
        .ok    (poll_ok),
        .tmo   (poll_tmo)
    );

    phy_pwrup_cfg_wr #(
        .CFG_HOLD (CFG_HOLD)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_load (addr_load),
        .start     (wr_start),
        .addr_in   (wr_addr),
        .data_in   (wr_data),
        .cfg_addr  (cfg_addr),
        .cfg_data  (cfg_data),
        .cfg_wr    (cfg_wr),
        .wr_done   (wr_done)
    );

    phy_pwrup_lanes #(
        .NLANES (NLANES),
        .IDX_W  (IDX_W)
    ) u_lanes (
        .clk           (clk),
        .rst_n         (rst_n),
        .lane          (lane_q),
        .clear_idle    (clear_idle),
        .set_on        (set_on),
        .tx_idle_force (tx_idle_force),
        .lanes_on      (lanes_on)
    );

endmodule

// File: rtl/phy_pwrup_sva.sv
module phy_pwrup_sva #(
    parameter int NLANES = 4,
    parameter int LANE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [LANE_W-1:0] cmd_lane,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [1:0]        err_code,
    input logic [NLANES-1:0] lanes_on,
    input logic [NLANES-1:0] tx_idle_force,
    input logic [5:0]        cfg_addr,
    input logic [3:0]        cfg_data,
    input logic              cfg_wr,
    input logic              cmd_reject
);

    a_r2_reject_cause: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> ($past(cmd_valid) && ($past(cmd_lane) >= LANE_W'(NLANES))));

    a_r4_end_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done ^ err));

    a_r4_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> !busy);

    a_r5_idle_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_idle_force != $past(tx_idle_force)) |-> busy);

    a_r5_idle_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((~$past(tx_idle_force)) & tx_idle_force) == '0);

    a_r7_setup_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_wr) |-> ($stable(cfg_addr) && $stable(cfg_data)));

    a_r7_strobe_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr || $fell(cfg_wr)) && $past(cfg_wr) |-> ($stable(cfg_addr) && $stable(cfg_data)));

    a_r10_done_ok: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err_code == 2'd0));

    a_r10_err_code: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_code != 2'd0));

    a_r10_bits_keep: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lanes_on) & ~lanes_on) == '0);

    a_r12_on_only_done: assert property (@(posedge clk) disable iff (!rst_n)
        (lanes_on != $past(lanes_on)) |-> done);

    a_r13_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(err_code));

endmodule

bind phy_pwrup_seq phy_pwrup_sva #(
    .NLANES (NLANES),
    .LANE_W (LANE_W)
) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_lane      (cmd_lane),
    .busy          (busy),
    .done          (done),
    .err           (err),
    .err_code      (err_code),
    .lanes_on      (lanes_on),
    .tx_idle_force (tx_idle_force),
    .cfg_addr      (cfg_addr),
    .cfg_data      (cfg_data),
    .cfg_wr        (cfg_wr),
    .cmd_reject    (cmd_reject)
);

// File: tb/phy_pwrup_seq_tb.sv
module phy_pwrup_seq_tb;

    localparam int NL    = 4;
    localparam int TRIES = 50;
    localparam int WAITC = 4;
    localparam int HOLD  = 2;
    localparam int LW    = 3;
    localparam int NEVER = 1_000_000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [LW-1:0] cmd_lane = '0;
    logic          pll_locked;
    logic          pll_out;
    logic          phy_rst, refclk_en, cfg_wr, busy, done, err, cmd_reject;
    logic [NL-1:0] tx_idle_force, lanes_on;
    logic [5:0]    cfg_addr;
    logic [3:0]    cfg_data;
    logic [1:0]    err_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit tb_done  = 1'b0;

    always #5 clk = ~clk;

    phy_pwrup_seq #(
        .NLANES(NL), .POLL_TRIES(TRIES), .POLL_WAIT(WAITC), .CFG_HOLD(HOLD), .LANE_W(LW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_lane(cmd_lane),
        .pll_locked(pll_locked), .pll_out(pll_out), .phy_rst(phy_rst), .refclk_en(refclk_en),
        .tx_idle_force(tx_idle_force), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_wr(cfg_wr),
        .busy(busy), .done(done), .err(err), .err_code(err_code), .lanes_on(lanes_on),
        .cmd_reject(cmd_reject)
    );

    // behavioural PLL status model and test-port monitor
    logic model_rst = 1'b0;
    int   m_lock_at = 0, m_out_at = 0, m_relock_at = 0;
    int   mph, mcnt, wr_cnt;
    logic wr_prev;
    logic [NL-1:0] tx_prev;
    logic [5:0] wr_a [0:3];
    logic [3:0] wr_d [0:3];
    bit   r5_seen, r5_good;

    always @(posedge clk) begin
        if (model_rst) begin
            mph <= 0; mcnt <= 0; pll_locked <= 1'b0; pll_out <= 1'b1;
            wr_cnt <= 0; r5_seen <= 1'b0; r5_good <= 1'b0;
        end else begin
            if (cfg_wr && !wr_prev) begin
                if (wr_cnt < 4) begin
                    wr_a[wr_cnt] <= cfg_addr;
                    wr_d[wr_cnt] <= cfg_data;
                end
                wr_cnt <= wr_cnt + 1;
            end
            if (tx_idle_force != tx_prev) begin
                r5_seen <= 1'b1;
                r5_good <= (cfg_addr == 6'h10) && !cfg_wr && !phy_rst;
            end
            case (mph)
                0: if (busy && !phy_rst) begin mph <= 1; mcnt <= 0; end
                1: if (mcnt >= m_lock_at) begin pll_locked <= 1'b1; mph <= 2; end
                   else mcnt <= mcnt + 1;
                2: if (cfg_wr && !wr_prev) begin
                       pll_locked <= 1'b0;
                       if (wr_cnt == 1) begin mph <= 3; mcnt <= 0; end
                   end
                3: if (mcnt >= m_out_at) begin pll_out <= 1'b0; mph <= 4; mcnt <= 0; end
                   else mcnt <= mcnt + 1;
                4: if (mcnt >= m_relock_at) begin pll_locked <= 1'b1; mph <= 5; end
                   else mcnt <= mcnt + 1;
                default: ;
            endcase
        end
        wr_prev <= cfg_wr;
        tx_prev <= tx_idle_force;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] op, input int lane);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_lane = LW'(lane);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // runs one enable; returns busy cycle count and end pulses
    task automatic run_en(input int lane, input int la, input int oa, input int ra,
                          input int intr, output int cyc, output bit d, output bit e);
        m_lock_at = la; m_out_at = oa; m_relock_at = ra;
        @(negedge clk) model_rst = 1'b1;
        @(negedge clk) model_rst = 1'b0;
        send(2'd1, lane);
        chk("R4 busy rises", int'(busy), 1);
        cyc = 0;
        while (busy && cyc < 20000) begin
            if (intr >= 0 && cyc == 6) begin
                cmd_valid = 1'b1; cmd_op = 2'd1; cmd_lane = LW'(intr);
            end else begin
                cmd_valid = 1'b0;
            end
            cyc++;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        d = done; e = err;
        if (cyc >= 20000) chk("R4 run end", 0, 1);
        @(negedge clk);
        chk("R4 single pulse", int'(done | err), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!tb_done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int cyc; bit d, e;
        logic [NL-1:0] exp_on, exp_idle;
        void'($urandom(32'h5EED_1234));
        model_rst = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        model_rst = 1'b0;

        // R1 reset state
        chk("R1 phy_rst", int'(phy_rst), 0);
        chk("R1 refclk_en", int'(refclk_en), 0);
        chk("R1 tx_idle_force", int'(tx_idle_force), 15);
        chk("R1 port", int'({cfg_addr, cfg_data, cfg_wr}), 0);
        chk("R1 status", int'({busy, done, err, err_code, cmd_reject}), 0);
        chk("R1 lanes_on", int'(lanes_on), 0);

        // R2 out-of-range lanes
        send(2'd1, 5);
        chk("R2 reject lane5", int'(cmd_reject), 1);
        chk("R2 no busy", int'(busy), 0);
        @(negedge clk);
        chk("R2 reject one cycle", int'(cmd_reject), 0);
        send(2'd0, 4);
        chk("R2 reject lane4", int'(cmd_reject), 1);
        chk("R2 no acquire", int'(refclk_en), 0);
        chk("R2 idle kept", int'(tx_idle_force), 15);

        // R3 acquire
        send(2'd0, 0);
        chk("R3 refclk_en", int'(refclk_en), 1);
        chk("R3 phy_rst", int'(phy_rst), 1);
        chk("R3 no busy", int'(busy), 0);

        // R6 lock timeout, exact duration
        run_en(1, NEVER, 0, 0, -1, cyc, d, e);
        chk("R6 busy cycles", cyc, 3 + TRIES + (TRIES - 1) * WAITC);
        chk("R6 err pulse", int'(e), 1);
        chk("R6 err_code", int'(err_code), 1);
        chk("R6 no writes", wr_cnt, 0);
        chk("R4 phy_rst released", int'(phy_rst), 0);
        chk("R5 only lane1 idle cleared", int'(tx_idle_force), 4'b1101);
        chk("R5 addr parked before clear", int'(r5_seen && r5_good), 1);
        chk("R10 no lane on after fail", int'(lanes_on), 0);
        repeat (5) @(negedge clk);
        chk("R13 err_code held", int'(err_code), 1);

        // R8 output timeout
        run_en(2, 3, NEVER, 0, -1, cyc, d, e);
        chk("R8 err_code", int'(err_code), 2);
        chk("R8 err pulse", int'(e), 1);
        chk("R7 two writes", wr_cnt, 2);
        chk("R7 first addr", int'(wr_a[0]), 'h10);
        chk("R7 first data", int'(wr_d[0]), 8);
        chk("R7 second addr", int'(wr_a[1]), 'h12);
        chk("R7 second data", int'(wr_d[1]), 8);

        // R9 relock timeout
        run_en(2, 0, 2, NEVER, -1, cyc, d, e);
        chk("R9 err_code", int'(err_code), 3);
        chk("R9 two strobes only", wr_cnt, 2);
        chk("R9 addr parked", int'(cfg_addr), 'h10);

        // R10 success with a command intruding while busy (R12)
        run_en(0, 7, 5, 9, 3, cyc, d, e);
        chk("R10 done pulse", int'(d), 1);
        chk("R10 no err", int'(e), 0);
        chk("R13 err_code cleared", int'(err_code), 0);
        chk("R10 lanes_on", int'(lanes_on), 1);
        chk("R12 lane3 not on", int'(lanes_on[3]), 0);
        chk("R12 lane3 idle kept", int'(tx_idle_force[3]), 1);
        chk("R9 final port", int'({cfg_addr, cfg_wr}), 'h10 << 1);
        chk("R7 order on success", int'({wr_a[0], wr_a[1]}), ('h10 << 6) | 'h12);

        // R11 disable and spare op
        send(2'd2, 0);
        chk("R11 disable no busy", int'(busy), 0);
        chk("R11 disable keeps bit", int'(lanes_on), 1);
        send(2'd3, 1);
        chk("R11 spare op ignored", int'({busy, lanes_on}), 1);

        // R6 late lock still inside the window
        run_en(1, 200, 1, 1, -1, cyc, d, e);
        chk("R6 late lock done", int'(d), 1);
        chk("R6 late lock lanes", int'(lanes_on), 3);

        // random successful runs mixed with ignored disables
        exp_on = lanes_on; exp_idle = tx_idle_force;
        for (int k = 0; k < 8; k++) begin
            int ln;
            ln = int'($urandom % NL);
            run_en(ln, int'($urandom % 120), int'($urandom % 60), int'($urandom % 60),
                   -1, cyc, d, e);
            exp_on[ln] = 1'b1; exp_idle[ln] = 1'b0;
            chk("R10 random done", int'(d), 1);
            chk("R10 random lanes_on", int'(lanes_on), int'(exp_on));
            chk("R5 random idle mask", int'(tx_idle_force), int'(exp_idle));
            chk("R7 random writes", wr_cnt, 2);
            send(2'd2, int'($urandom % NL));
            chk("R11 random disable", int'(lanes_on), int'(exp_on));
        end

        tb_done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule